// File: doc/BRIEF.md
# Two-Wire Slave Address Recognizer with SMBus Special Addresses

This block is the address-recognition and acknowledge core of a two-wire (I2C/SMBus) slave. It watches the sampled clock and data lines, finds START and STOP conditions, and shifts in the address byte that follows each START. It then decides whether the slave answers. It matches a 7-bit or a 10-bit own address. It can also answer three fixed SMBus addresses, each with its own enable.

Once an address is accepted, the block can hold the clock line low until software lets it go. In write transfers it drives the acknowledge bit of each data byte with a polarity that software chooses. It keeps a byte counter that counts up or down, and it drives an open-drain alert line. Every line output is a pull-down enable. The surrounding slave supplies the configuration fields as plain inputs and reads the match flags back.

Top module: `tws_addr_matcher`

## Requirements
- R1: With `cfg_ten_bit`=0, a first byte whose bits 7:1 equal `cfg_own_addr[6:0]` is acknowledged (`sda_pd`=1 during the ninth clock) and sets `hit_own`. Bit 0 of that byte is the direction (1 = read) and appears on `rw_dir`. With `cfg_ten_bit`=1 such a byte is not acknowledged.
- R2: With `cfg_ten_bit`=1, a first byte `11110`,A9,A8,R/W is acknowledged only if A9:A8 equal `cfg_own_addr[9:8]`. The following byte is acknowledged, and `hit_own` set, only if it equals `cfg_own_addr[7:0]`.
- R3: The first-byte address 7'b0001000 is acknowledged, and sets `hit_host`, only while `cfg_host_en`=1.
- R4: The first-byte address 7'b1100001 is acknowledged, and sets `hit_dflt`, only while `cfg_dflt_en`=1.
- R5: `alert_pd` equals `cfg_alert` one clock later. The first-byte address 7'b0001100 is acknowledged, and sets `hit_alert`, only while `cfg_alert`=1.
- R6: With `cfg_stretch_en`=1, `scl_pd` rises after the acknowledge bit of a completed address match ends, and it stays high until a `stretch_release` pulse. With `cfg_stretch_en`=0, `scl_pd` never rises.
- R7: In write transfers, `sda_pd` during the acknowledge bit of each data byte equals the inverse of `cfg_data_nack`. In read transfers the block never drives `sda_pd`.
- R8: `byte_cnt` is 0 after reset. It moves by one, with wrap-around, at the end of each data byte: up when `cfg_count_up`=1 and down otherwise. Address bytes do not count.
- R9: A STOP, or a repeated START, clears every hit flag and stops the transfer in progress. After a repeated START the next byte is treated as a new address.
- R10: A one-cycle `sw_reset` returns the block to idle. It clears the hit flags and `byte_cnt` and releases `sda_pd`, `scl_pd` and `alert_pd`. Bus activity after it is ignored until the next START.
- R11: `sda_pd` changes only while the sampled clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Sampled bus clock line |
| sda_in | input | 1 | Sampled bus data line |
| cfg_ten_bit | input | 1 | Select 10-bit own address |
| cfg_own_addr | input | 10 | Own slave address |
| cfg_stretch_en | input | 1 | Hold clock low after an address match |
| cfg_count_up | input | 1 | Byte counter direction, 1 = up |
| cfg_data_nack | input | 1 | Level driven in data acknowledge bits, 1 = not-acknowledge |
| cfg_host_en | input | 1 | Answer the SMBus host header |
| cfg_dflt_en | input | 1 | Answer the SMBus default address |
| cfg_alert | input | 1 | Pull alert line and answer the alert response address |
| sw_reset | input | 1 | Software reset pulse |
| stretch_release | input | 1 | Software release of clock stretching |
| sda_pd | output | 1 | Data line pull-down enable |
| scl_pd | output | 1 | Clock line pull-down enable |
| alert_pd | output | 1 | Alert line pull-down enable |
| rw_dir | output | 1 | Direction bit of the accepted address, 1 = read |
| hit_own | output | 1 | Own address matched |
| hit_host | output | 1 | Host header matched |
| hit_dflt | output | 1 | Default address matched |
| hit_alert | output | 1 | Alert response address matched |
| byte_cnt | output | CNT_W | Data byte counter |

## Verification
Random configurations are paired with address bytes picked from the own 7-bit address, the 10-bit header with correct and wrong upper bits, the three special addresses and arbitrary values. This separates a match made by the right comparator from one that only passes because an enable happens to be set. Data phases of random length and direction tell write acknowledge polarity apart from read silence, and show the counter stepping in both directions. Directed cases cover a counter wrap from zero, a stretch held across many cycles, a repeated START and a software reset mid-transfer, which show whether the abort paths really clear state.

// File: rtl/tws_pkg.sv
// Shared types and constants of the two-wire slave address recognizer.
// Assumes a standard 8-bit byte frame on the bus.
package tws_pkg;
    localparam int BYTE_W   = 8;
    localparam int ADDR7_W  = 7;
    localparam int OWN_W    = 10;
    localparam int BITCNT_W = $clog2(BYTE_W) + 1;

    localparam logic [ADDR7_W-1:0] HOST_HDR_ADDR = 7'b0001000;
    localparam logic [ADDR7_W-1:0] DFLT_ADDR     = 7'b1100001;
    localparam logic [ADDR7_W-1:0] ARA_ADDR      = 7'b0001100;
    localparam logic [4:0]         TEN_PREFIX    = 5'b11110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADR1,
        ST_ACK1,
        ST_ADR2,
        ST_ACK2,
        ST_DATA,
        ST_DACK,
        ST_SKIP
    } tws_state_e;

    typedef struct packed {
        logic own;
        logic host;
        logic dflt;
        logic alert;
    } tws_hits_t;
endpackage

// File: rtl/tws_bus_cond.sv
// Bus condition detector: finds START, STOP and clock edges from the
// sampled lines. Assumes scl_in/sda_in are already synchronized.
module tws_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic start_det,
    output logic stop_det,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_q;
    logic sda_q;

    // Keep the previous sample of both lines (idle bus is high).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_in;
            sda_q <= sda_in;
        end
    end

    // Data edges while the clock stays high are bus conditions.
    always_comb begin
        start_det = scl_q && scl_in && sda_q && !sda_in;
        stop_det  = scl_q && scl_in && !sda_q && sda_in;
        scl_rise  = !scl_q && scl_in;
        scl_fall  = scl_q && !scl_in;
    end
endmodule

// File: rtl/tws_addr_cmp.sv
// Address comparator: judges a received byte against the own address and
// the enabled special addresses. The first byte is compared on bits 7:1;
// the second byte of a 10-bit address is compared whole.
module tws_addr_cmp
    import tws_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              is_second,
    input  logic              cfg_ten_bit,
    input  logic [OWN_W-1:0]  cfg_own_addr,
    input  logic              cfg_host_en,
    input  logic              cfg_dflt_en,
    input  logic              cfg_alert,
    output tws_hits_t         hits,
    output logic              ten_hdr,
    output logic              hit_any
);
    logic [ADDR7_W-1:0] a7;

    // Evaluate every comparator for the byte kind being judged.
    always_comb begin
        a7      = byte_in[BYTE_W-1:1];
        hits    = '0;
        ten_hdr = 1'b0;
        if (is_second) begin
            hits.own = cfg_ten_bit && (byte_in == cfg_own_addr[BYTE_W-1:0]);
        end else begin
            hits.own   = !cfg_ten_bit && (a7 == cfg_own_addr[ADDR7_W-1:0]);
            hits.host  = cfg_host_en && (a7 == HOST_HDR_ADDR);
            hits.dflt  = cfg_dflt_en && (a7 == DFLT_ADDR);
            hits.alert = cfg_alert && (a7 == ARA_ADDR);
            ten_hdr    = cfg_ten_bit && (a7[6:2] == TEN_PREFIX)
                         && (a7[1:0] == cfg_own_addr[OWN_W-1:BYTE_W]);
        end
        hit_any = (|hits) || ten_hdr;
    end
endmodule

// File: rtl/tws_byte_cnt.sv
// Up/down byte counter with wrap-around and a synchronous clear.
// Assumes step is a single-cycle pulse per transferred byte.
module tws_byte_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic             up,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Step the count in the selected direction.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= up ? cnt + ONE : cnt - ONE;
        end
    end
endmodule

// File: rtl/tws_addr_matcher.sv
// Two-wire slave address recognizer. It follows the address phase after
// each START, acknowledges own and enabled SMBus special addresses,
// optionally stretches the clock on a match, acknowledges write data
// with a configurable level and counts data bytes.
// Assumes sampled lines and configuration held stable during a transfer.
module tws_addr_matcher
    import tws_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             cfg_ten_bit,
    input  logic [9:0]       cfg_own_addr,
    input  logic             cfg_stretch_en,
    input  logic             cfg_count_up,
    input  logic             cfg_data_nack,
    input  logic             cfg_host_en,
    input  logic             cfg_dflt_en,
    input  logic             cfg_alert,
    input  logic             sw_reset,
    input  logic             stretch_release,
    output logic             sda_pd,
    output logic             scl_pd,
    output logic             alert_pd,
    output logic             rw_dir,
    output logic             hit_own,
    output logic             hit_host,
    output logic             hit_dflt,
    output logic             hit_alert,
    output logic [CNT_W-1:0] byte_cnt
);
    localparam logic [BITCNT_W-1:0] FULL = BITCNT_W'(BYTE_W);

    tws_state_e          state;
    logic [BYTE_W-1:0]   shreg;
    logic [BITCNT_W-1:0] bitcnt;
    logic                ten_path;
    logic                hold;
    tws_hits_t           hit_q;
    logic                start_det, stop_det, scl_rise, scl_fall;
    tws_hits_t           cmp_hits;
    logic                cmp_ten_hdr, cmp_any;
    logic                cnt_step;
    logic                byte_done;

    tws_bus_cond i_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .start_det (start_det),
        .stop_det  (stop_det),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall)
    );

    tws_addr_cmp i_cmp (
        .byte_in      (shreg),
        .is_second    (state == ST_ADR2),
        .cfg_ten_bit  (cfg_ten_bit),
        .cfg_own_addr (cfg_own_addr),
        .cfg_host_en  (cfg_host_en),
        .cfg_dflt_en  (cfg_dflt_en),
        .cfg_alert    (cfg_alert),
        .hits         (cmp_hits),
        .ten_hdr      (cmp_ten_hdr),
        .hit_any      (cmp_any)
    );

    // A data byte ends when the clock falls after its acknowledge bit.
    assign cnt_step = (state == ST_DACK) && scl_fall && !start_det
                      && !stop_det && !sw_reset;

    tws_byte_cnt #(.CNT_W(CNT_W)) i_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sw_reset),
        .step  (cnt_step),
        .up    (cfg_count_up),
        .cnt   (byte_cnt)
    );

    // Eight bits shifted and the clock now low: time to decide.
    assign byte_done = scl_fall && (bitcnt == FULL);

    // Protocol sequencer: shifting, acknowledge decisions, stretch, aborts.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_reset) begin
            state    <= ST_IDLE;
            shreg    <= '0;
            bitcnt   <= '0;
            ten_path <= 1'b0;
            hold     <= 1'b0;
            hit_q    <= '0;
            sda_pd   <= 1'b0;
            rw_dir   <= 1'b0;
        end else if (start_det || stop_det) begin
            state  <= start_det ? ST_ADR1 : ST_IDLE;
            bitcnt <= '0;
            hold   <= 1'b0;
            hit_q  <= '0;
            sda_pd <= 1'b0;
        end else begin
            if (stretch_release) begin
                hold <= 1'b0;
            end
            unique case (state)
                ST_ADR1, ST_ADR2, ST_DATA: begin
                    if (scl_rise && bitcnt != FULL) begin
                        shreg  <= {shreg[BYTE_W-2:0], sda_in};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (byte_done) begin
                        if (state == ST_ADR1) begin
                            if (cmp_any) begin
                                sda_pd   <= 1'b1;
                                state    <= ST_ACK1;
                                ten_path <= cmp_ten_hdr;
                                rw_dir   <= shreg[0];
                                hit_q    <= cmp_hits;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end else if (state == ST_ADR2) begin
                            if (cmp_hits.own) begin
                                sda_pd    <= 1'b1;
                                state     <= ST_ACK2;
                                hit_q.own <= 1'b1;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end else begin
                            sda_pd <= !rw_dir && !cfg_data_nack;
                            state  <= ST_DACK;
                        end
                    end
                end
                ST_ACK1: begin
                    if (scl_fall) begin
                        sda_pd <= 1'b0;
                        bitcnt <= '0;
                        if (ten_path) begin
                            state <= ST_ADR2;
                        end else begin
                            state <= ST_DATA;
                            hold  <= cfg_stretch_en && !stretch_release;
                        end
                    end
                end
                ST_ACK2: begin
                    if (scl_fall) begin
                        sda_pd <= 1'b0;
                        bitcnt <= '0;
                        state  <= ST_DATA;
                        hold   <= cfg_stretch_en && !stretch_release;
                    end
                end
                ST_DACK: begin
                    if (scl_fall) begin
                        sda_pd <= 1'b0;
                        bitcnt <= '0;
                        state  <= ST_DATA;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // Alert line follows its configuration bit, dropped by software reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alert_pd <= 1'b0;
        end else begin
            alert_pd <= cfg_alert && !sw_reset;
        end
    end

    assign scl_pd    = hold;
    assign hit_own   = hit_q.own;
    assign hit_host  = hit_q.host;
    assign hit_dflt  = hit_q.dflt;
    assign hit_alert = hit_q.alert;
endmodule

// File: rtl/tws_addr_matcher_chk.sv
// Property checker for tws_addr_matcher, attached through bind.
module tws_addr_matcher_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_in,
    input logic             sw_reset,
    input logic             stretch_release,
    input logic             cfg_stretch_en,
    input logic             cfg_count_up,
    input logic             cfg_host_en,
    input logic             cfg_dflt_en,
    input logic             cfg_alert,
    input logic             sda_pd,
    input logic             scl_pd,
    input logic             alert_pd,
    input logic             hit_own,
    input logic             hit_host,
    input logic             hit_dflt,
    input logic             hit_alert,
    input logic [CNT_W-1:0] byte_cnt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // R11
    sda_low_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(sw_reset) && (sda_pd != $past(sda_pd)))
        |-> !$past(scl_in));

    // R5
    alert_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (alert_pd == ($past(cfg_alert) && !$past(sw_reset))));

    // R5
    ara_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit_alert) |-> $past(cfg_alert));

    // R3
    host_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit_host) |-> $past(cfg_host_en));

    // R4
    dflt_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit_dflt) |-> $past(cfg_dflt_en));

    // R6
    stretch_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pd) |-> $past(cfg_stretch_en));

    // R6
    stretch_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(stretch_release)) |-> !scl_pd);

    // R8
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(sw_reset) && (byte_cnt != $past(byte_cnt)))
        |-> (byte_cnt == ($past(cfg_count_up) ? $past(byte_cnt) + ONE
                                              : $past(byte_cnt) - ONE)));

    // R10
    sw_reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sw_reset)) |->
        (!sda_pd && !scl_pd && !alert_pd && (byte_cnt == '0)
         && !hit_own && !hit_host && !hit_dflt && !hit_alert));
endmodule

bind tws_addr_matcher tws_addr_matcher_chk #(.CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_tws_addr_matcher.sv
module test_tws_addr_matcher;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic cfg_ten_bit = 1'b0;
    logic [9:0] cfg_own_addr = '0;
    logic cfg_stretch_en = 1'b0;
    logic cfg_count_up = 1'b0;
    logic cfg_data_nack = 1'b0;
    logic cfg_host_en = 1'b0;
    logic cfg_dflt_en = 1'b0;
    logic cfg_alert = 1'b0;
    logic sw_reset = 1'b0;
    logic stretch_release = 1'b0;
    logic sda_pd, scl_pd, alert_pd, rw_dir;
    logic hit_own, hit_host, hit_dflt, hit_alert;
    logic [CNT_W-1:0] byte_cnt;
    logic scl_bus, sda_bus;

    int checks = 0;
    int errors = 0;
    int edge_viol = 0;
    logic rd_seen = 1'b0;
    logic [CNT_W-1:0] exp_cnt = '0;

    assign scl_bus = scl_m & ~scl_pd;
    assign sda_bus = sda_m & ~sda_pd;

    always #5 clk = ~clk;

    tws_addr_matcher #(.CNT_W(CNT_W)) i_tws_addr_matcher (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_bus), .sda_in(sda_bus),
        .cfg_ten_bit(cfg_ten_bit), .cfg_own_addr(cfg_own_addr),
        .cfg_stretch_en(cfg_stretch_en), .cfg_count_up(cfg_count_up),
        .cfg_data_nack(cfg_data_nack), .cfg_host_en(cfg_host_en),
        .cfg_dflt_en(cfg_dflt_en), .cfg_alert(cfg_alert),
        .sw_reset(sw_reset), .stretch_release(stretch_release),
        .sda_pd(sda_pd), .scl_pd(scl_pd), .alert_pd(alert_pd),
        .rw_dir(rw_dir), .hit_own(hit_own), .hit_host(hit_host),
        .hit_dflt(hit_dflt), .hit_alert(hit_alert), .byte_cnt(byte_cnt)
    );

    // R11 monitor: data pull-down must not move across a clock-high stretch.
    logic pd_prev = 1'b0;
    logic scl_prev = 1'b1;
    always @(negedge clk) begin
        if (rst_n && (sda_pd !== pd_prev) && scl_prev && scl_bus) edge_viol++;
        if (sda_pd) rd_seen <= 1'b1;
        pd_prev  <= sda_pd;
        scl_prev <= scl_bus;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic half();
        repeat (3) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; half();
        scl_m = 1'b1; half();
        sda_m = 1'b0; half();
        scl_m = 1'b0; half();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; half();
        scl_m = 1'b1; half();
        sda_m = 1'b1; half();
    endtask

    // Master writes a byte; returns the slave's pull-down in the ack bit.
    task automatic send_byte(input logic [7:0] b, output logic ackpd);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; half();
            scl_m = 1'b1;
            while (!scl_bus) @(negedge clk);
            half();
            scl_m = 1'b0; half();
        end
        sda_m = 1'b1; half();
        ackpd = sda_pd;
        scl_m = 1'b1; half();
        scl_m = 1'b0; half();
    endtask

    // Master reads a byte with the line released, then acknowledges it.
    task automatic read_byte();
        rd_seen = 1'b0;
        for (int i = 0; i < 9; i++) begin
            sda_m = (i == 8) ? 1'b0 : 1'b1; half();
            scl_m = 1'b1; half();
            scl_m = 1'b0; half();
        end
        sda_m = 1'b1;
    endtask

    function automatic logic exp_ack1(input logic [7:0] b);
        logic [6:0] a;
        a = b[7:1];
        return (!cfg_ten_bit && a == cfg_own_addr[6:0]) ||
               (cfg_host_en && a == 7'b0001000) ||
               (cfg_dflt_en && a == 7'b1100001) ||
               (cfg_alert && a == 7'b0001100) ||
               (cfg_ten_bit && a[6:2] == 5'b11110 && a[1:0] == cfg_own_addr[9:8]);
    endfunction

    function automatic logic [3:0] exp_hits1(input logic [7:0] b);
        logic [6:0] a;
        a = b[7:1];
        return {!cfg_ten_bit && a == cfg_own_addr[6:0],
                cfg_host_en && a == 7'b0001000,
                cfg_dflt_en && a == 7'b1100001,
                cfg_alert && a == 7'b0001100};
    endfunction

    function automatic logic [CNT_W-1:0] next_cnt(input logic [CNT_W-1:0] c);
        return cfg_count_up ? c + 1'b1 : c - 1'b1;
    endfunction

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic a;
        logic [7:0] b1, b2, d;
        logic full;
        int kind, nb, seed;
        seed = $urandom(32'd20240611);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        half();
        // Reset state
        chk(sda_pd == 0 && scl_pd == 0 && alert_pd == 0, "R10 reset lines", {sda_pd, scl_pd, alert_pd}, 0);
        chk(byte_cnt == 0, "R8 reset count", byte_cnt, 0);

        // R5: alert line follows its bit
        cfg_alert = 1'b1; @(negedge clk); @(negedge clk);
        chk(alert_pd == 1, "R5 alert set", alert_pd, 1);
        cfg_alert = 1'b0; @(negedge clk); @(negedge clk);
        chk(alert_pd == 0, "R5 alert clear", alert_pd, 0);

        // R1 + R8 wrap: own 7-bit write, one data byte counting down from 0
        cfg_own_addr = 10'h25A; cfg_count_up = 1'b0;
        bus_start(); send_byte({7'h5A, 1'b0}, a);
        chk(a == 1 && hit_own == 1 && rw_dir == 0, "R1 own7 ack", {a, hit_own, rw_dir}, 3'b110);
        send_byte(8'hC3, a);
        chk(a == 1, "R7 data ack", a, 1);
        chk(byte_cnt == 8'hFF, "R8 wrap down", byte_cnt, 8'hFF);
        bus_stop();
        chk(hit_own == 0, "R9 stop clears", hit_own, 0);

        // R1: 10-bit mode refuses the 7-bit form
        cfg_ten_bit = 1'b1;
        bus_start(); send_byte({7'h5A, 1'b0}, a);
        chk(a == 0, "R1 ten-bit ignores 7-bit", a, 0);
        bus_stop();

        // R2: header with wrong upper bits
        bus_start(); send_byte({5'b11110, 2'b01, 1'b0}, a);
        chk(a == 0, "R2 header mismatch", a, 0);
        bus_stop();

        // R6: stretch on a 10-bit match, then release
        cfg_stretch_en = 1'b1;
        bus_start(); send_byte({5'b11110, 2'b10, 1'b0}, a);
        chk(a == 1 && scl_pd == 0, "R2 header ack no stretch", {a, scl_pd}, 2'b10);
        send_byte(8'h5A, a);
        chk(a == 1 && hit_own == 1, "R2 second byte ack", {a, hit_own}, 2'b11);
        chk(scl_pd == 1, "R6 stretch set", scl_pd, 1);
        repeat (20) @(negedge clk);
        chk(scl_pd == 1, "R6 stretch held", scl_pd, 1);
        stretch_release = 1'b1; @(negedge clk); stretch_release = 1'b0; @(negedge clk);
        chk(scl_pd == 0, "R6 stretch released", scl_pd, 0);
        bus_stop();
        cfg_stretch_en = 1'b0; cfg_ten_bit = 1'b0;

        // R9: repeated START restarts address recognition
        cfg_host_en = 1'b1;
        bus_start(); send_byte({7'h08, 1'b0}, a);
        chk(a == 1 && hit_host == 1 && scl_pd == 0, "R3 host ack", {a, hit_host, scl_pd}, 3'b110);
        bus_start();
        chk(hit_host == 0, "R9 repeated start clears", hit_host, 0);
        send_byte({7'h61, 1'b0}, a);
        chk(a == 0, "R4 default disabled", a, 0);
        bus_stop();

        // R10: software reset in the middle of a write
        cfg_count_up = 1'b1;
        bus_start(); send_byte({7'h5A, 1'b0}, a);
        send_byte(8'h11, a);
        @(negedge clk); sw_reset = 1'b1; @(negedge clk); sw_reset = 1'b0; @(negedge clk);
        chk(byte_cnt == 0 && hit_own == 0, "R10 sw reset clears", {byte_cnt, hit_own}, 0);
        send_byte(8'h22, a);
        chk(a == 0 && byte_cnt == 0, "R10 bus ignored after reset", {a, byte_cnt}, 0);
        bus_stop();
        exp_cnt = '0;

        // Random transactions
        for (int t = 0; t < 70; t++) begin
            cfg_ten_bit   = $urandom % 2;
            cfg_own_addr  = $urandom;
            cfg_count_up  = $urandom % 2;
            cfg_data_nack = $urandom % 2;
            cfg_host_en   = $urandom % 2;
            cfg_dflt_en   = $urandom % 2;
            cfg_alert     = $urandom % 2;
            repeat (2) @(negedge clk);
            chk(alert_pd == cfg_alert, "R5 alert random", alert_pd, cfg_alert);
            kind = $urandom % 6;
            case (kind)
                0: b1[7:1] = cfg_own_addr[6:0];
                1: b1[7:1] = {5'b11110, ($urandom % 4 == 0) ? 2'($urandom) : cfg_own_addr[9:8]};
                2: b1[7:1] = 7'h08;
                3: b1[7:1] = 7'h61;
                4: b1[7:1] = 7'h0C;
                default: b1[7:1] = 7'($urandom);
            endcase
            b1[0] = $urandom % 2;
            bus_start(); send_byte(b1, a);
            chk(a == exp_ack1(b1), kind == 1 ? "R2 header" : kind == 2 ? "R3 host" :
                kind == 3 ? "R4 default" : kind == 4 ? "R5 alert response" : "R1 own7",
                a, exp_ack1(b1));
            full = exp_ack1(b1);
            if (full && cfg_ten_bit && b1[7:3] == 5'b11110) begin
                b2 = ($urandom % 3 != 0) ? cfg_own_addr[7:0] : 8'($urandom);
                send_byte(b2, a);
                full = (b2 == cfg_own_addr[7:0]);
                chk(a == full && hit_own == full, "R2 second byte", {a, hit_own}, {full, full});
            end else if (full) begin
                chk({hit_own, hit_host, hit_dflt, hit_alert} == exp_hits1(b1), "R1 hit flags",
                    {hit_own, hit_host, hit_dflt, hit_alert}, exp_hits1(b1));
            end
            chk(scl_pd == 0, "R6 no stretch when disabled", scl_pd, 0);
            if (full) begin
                nb = $urandom % 3;
                for (int k = 0; k < nb; k++) begin
                    if (!b1[0]) begin
                        d = $urandom;
                        send_byte(d, a);
                        chk(a == !cfg_data_nack, "R7 write ack level", a, !cfg_data_nack);
                    end else begin
                        read_byte();
                        chk(rd_seen == 0, "R7 read never drives", rd_seen, 0);
                    end
                    exp_cnt = next_cnt(exp_cnt);
                    chk(byte_cnt == exp_cnt, "R8 count step", byte_cnt, exp_cnt);
                end
            end
            bus_stop();
            chk({hit_own, hit_host, hit_dflt, hit_alert} == 0, "R9 stop clears flags",
                {hit_own, hit_host, hit_dflt, hit_alert}, 0);
        end

        chk(edge_viol == 0, "R11 data changes with clock low", edge_viol, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule